// File: doc/BRIEF.md
# Table-Access Flash Program Controller

This block gives a CPU core byte-wide access to a word-organised program store that it models internally. A 22-bit table pointer addresses single bytes. A table read copies the addressed byte into an 8-bit table latch. A table write copies the latch into one of 64 staging bytes, and the staging slot is picked by the pointer's six low bits. The pointer can step after or before each access.

A start command begins a timed operation on one 64-byte block. The block is selected by the pointer bits above bit 5, and the six low bits play no part. The operation either programs the whole staging buffer into the block or sets the block to 0xFF. The choice comes from an erase-select bit that is written together with the start bit. A write-enable bit guards every start. While the programming timer runs, a busy flag is high and the table-command stream is back-pressured.

Table commands arrive on a valid/ready stream: a command is accepted in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low for the whole timed operation, and the CPU must hold the command stable until it is accepted. Pointer load, latch load and control writes are plain strobes that are never stalled.

Top module: `tblflash_ctrl`

## Requirements
- R1: After reset, `ptr` is 0, `tablat` is 0, `ctl_wren`, `ctl_erase`, `busy` and `err` are 0, `cmd_ready` is 1, and every stored byte reads 0xFF.
- R2: An accepted read (`cmd_op`=0) loads `tablat` one cycle later with the byte at the access address. Only address bits MEM_LG-1:0 select the byte, so higher pointer bits alias. Within a 16-bit word, address bit 0 = 0 selects the low byte and 1 selects the high byte.
- R3: `cmd_mode` sets the pointer update and the access address. 0 = no change. 1 = access at `ptr`, then add 1. 2 = access at `ptr`, then subtract 1. 3 = add 1, then access at the new value. Arithmetic wraps modulo 2^22. The pointer changes only through an accepted command or through `ptr_we`.
- R4: An accepted write (`cmd_op`=1) stores `tablat` into staging slot access-address[5:0]. The program store does not change until a commit.
- R5: A control write with `ctl_wdata` bit 2 (start) = 1, bit 0 (enable) = 1 and bit 1 (erase) = 0, issued while not busy, programs all 64 staging bytes into block `ptr`[MEM_LG-1:6] at the end of the timed operation. Staging slot i goes to block byte i, and `ptr`[5:0] is ignored.
- R6: The same start with bit 1 = 1 sets all 64 bytes of the selected block to 0xFF and leaves the other blocks unchanged.
- R7: `busy` rises the cycle after an accepted start and stays high for exactly PROG_CYC cycles. While it is high, `cmd_ready` is 0 and `tablat` and `ptr` do not respond to commands.
- R8: A start issued while `busy` is high neither restarts nor extends the operation.
- R9: A start with bit 0 = 0 sets `err` in the next cycle, does not raise `busy`, and leaves the store unchanged. The next accepted start clears `err`.
- R10: After every commit, whether write or erase, all staging bytes return to 0xFF.
- R11: A control write stores bit 0 in `ctl_wren` and bit 1 in `ctl_erase`. The start bit is a one-cycle pulse that is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Table command valid |
| cmd_ready | output | 1 | Table command ready (low while busy) |
| cmd_op | input | 1 | 0 = table read, 1 = table write |
| cmd_mode | input | 2 | Pointer update mode |
| ptr_we | input | 1 | Load the pointer |
| ptr_wdata | input | PTR_W | Pointer load value |
| ptr | output | PTR_W | Current table pointer |
| lat_we | input | 1 | Load the table latch |
| lat_wdata | input | 8 | Latch load value |
| tablat | output | 8 | Table latch |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | {start, erase, enable} |
| ctl_wren | output | 1 | Stored write-enable bit |
| ctl_erase | output | 1 | Stored erase-select bit |
| busy | output | 1 | Timed operation in progress |
| err | output | 1 | Start attempted without enable |

## Verification
The assertions check several things on every cycle. An enabled start must raise `busy`. A disabled start must raise `err` and not `busy`. A busy period must never run longer than PROG_CYC cycles. The latch and pointer must stay still while stalled, and the pointer must stay still when nothing addresses it. Only the bench scenarios can show data correctness. They fill every block of a small store and read it back, sweep the pointer modes and the 22-bit wrap, erase one block, write a nearly empty staging buffer after an erase, and confirm that a refused start leaves memory intact.

// File: rtl/tblflash_pkg.sv
package tblflash_pkg;
  typedef enum logic {OP_RD = 1'b0, OP_WT = 1'b1} tbl_op_e;
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_POSTINC = 2'd1,
    UPD_POSTDEC = 2'd2,
    UPD_PREINC  = 2'd3
  } upd_mode_e;
endpackage

// File: rtl/tblptr_unit.sv
module tblptr_unit
  import tblflash_pkg::*;
#(
  parameter int PTR_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  input  upd_mode_e        mode,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] acc_addr
);
  logic [PTR_W-1:0] ptr_inc, ptr_dec, ptr_nxt;

  assign ptr_inc  = ptr_q + PTR_W'(1);
  assign ptr_dec  = ptr_q - PTR_W'(1);
  assign acc_addr = (mode == UPD_PREINC) ? ptr_inc : ptr_q;

  always_comb begin
    unique case (mode)
      UPD_NONE:    ptr_nxt = ptr_q;
      UPD_POSTDEC: ptr_nxt = ptr_dec;
      default:     ptr_nxt = ptr_inc;
    endcase
  end

  // an accepted command takes precedence over a load in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (step)  ptr_q <= ptr_nxt;
    else if (load)  ptr_q <= load_val;
  end
endmodule

// File: rtl/hold_buf.sv
module hold_buf #(
  parameter int BLK_LG = 6,
  localparam int NB    = 2 ** BLK_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BLK_LG-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              clr,
  output logic [NB*8-1:0]   flat
);
  for (genvar i = 0; i < NB; i++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_q <= 8'hFF;
      else if (clr)                              slot_q <= 8'hFF;
      else if (wr_en && wr_idx == BLK_LG'(i))    slot_q <= wr_data;
    end
    assign flat[i*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int MEM_LG  = 9,
  parameter int BLK_LG  = 6,
  localparam int WORDS  = 2 ** (MEM_LG - 1),
  localparam int WPB    = 2 ** (BLK_LG - 1),
  localparam int NBLK_W = MEM_LG - BLK_LG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MEM_LG-1:0]       rd_addr,
  output logic [7:0]              rd_byte,
  input  logic                    commit,
  input  logic                    commit_erase,
  input  logic [NBLK_W-1:0]       commit_blk,
  input  logic [(2**BLK_LG)*8-1:0] commit_data
);
  logic [15:0] mem [WORDS];
  logic [15:0] rd_word;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int LW = w % WPB;
    localparam int BK = w / WPB;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[w] <= 16'hFFFF;
      else if (commit && commit_blk == NBLK_W'(BK))
        mem[w] <= commit_erase ? 16'hFFFF : commit_data[LW*16 +: 16];
    end
  end

  assign rd_word = mem[rd_addr[MEM_LG-1:1]];
  assign rd_byte = rd_addr[0] ? rd_word[15:8] : rd_word[7:0];
endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int PROG_CYC = 16,
  parameter int BLKW     = 3,
  localparam int CW      = $clog2(PROG_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            wren,
  input  logic            erase_sel,
  input  logic [BLKW-1:0] blk_in,
  output logic            busy,
  output logic            err,
  output logic            commit,
  output logic            commit_erase,
  output logic [BLKW-1:0] commit_blk
);
  logic [CW-1:0] cnt_q;

  assign commit = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      err          <= 1'b0;
      cnt_q        <= '0;
      commit_erase <= 1'b0;
      commit_blk   <= '0;
    end else if (busy) begin
      if (cnt_q == '0) busy  <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end else if (start_req) begin
      if (!wren) begin
        err <= 1'b1;
      end else begin
        err          <= 1'b0;
        busy         <= 1'b1;
        cnt_q        <= CW'(PROG_CYC - 1);
        commit_erase <= erase_sel;
        commit_blk   <= blk_in;
      end
    end
  end
endmodule

// File: rtl/tblflash_ctrl.sv
module tblflash_ctrl
  import tblflash_pkg::*;
#(
  parameter int PTR_W    = 22,
  parameter int MEM_LG   = 9,
  parameter int BLK_LG   = 6,
  parameter int PROG_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_op,
  input  logic [1:0]       cmd_mode,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] ptr_wdata,
  output logic [PTR_W-1:0] ptr,
  input  logic             lat_we,
  input  logic [7:0]       lat_wdata,
  output logic [7:0]       tablat,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_wdata,
  output logic             ctl_wren,
  output logic             ctl_erase,
  output logic             busy,
  output logic             err
);
  localparam int NBLK_W = MEM_LG - BLK_LG;
  localparam int HB_W   = (2 ** BLK_LG) * 8;

  logic             acc, rd_acc, wt_acc, start_req, commit, commit_erase;
  logic [PTR_W-1:0] acc_addr;
  logic [7:0]       rd_byte;
  logic [HB_W-1:0]  hb_flat;
  logic [NBLK_W-1:0] commit_blk;
  logic             unused_hi;

  assign cmd_ready = !busy;
  assign acc       = cmd_valid && cmd_ready;
  assign rd_acc    = acc && (tbl_op_e'(cmd_op) == OP_RD);
  assign wt_acc    = acc && (tbl_op_e'(cmd_op) == OP_WT);
  assign start_req = ctl_we && ctl_wdata[2];
  assign unused_hi = ^{ptr[PTR_W-1:MEM_LG], ptr[BLK_LG-1:0], acc_addr[PTR_W-1:MEM_LG]};

  tblptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk, .rst_n, .load(ptr_we), .load_val(ptr_wdata), .step(acc),
    .mode(upd_mode_e'(cmd_mode)), .ptr_q(ptr), .acc_addr(acc_addr)
  );

  hold_buf #(.BLK_LG(BLK_LG)) u_hold (
    .clk, .rst_n, .wr_en(wt_acc), .wr_idx(acc_addr[BLK_LG-1:0]),
    .wr_data(tablat), .clr(commit), .flat(hb_flat)
  );

  flash_array #(.MEM_LG(MEM_LG), .BLK_LG(BLK_LG)) u_mem (
    .clk, .rst_n, .rd_addr(acc_addr[MEM_LG-1:0]), .rd_byte(rd_byte),
    .commit(commit), .commit_erase(commit_erase), .commit_blk(commit_blk),
    .commit_data(hb_flat)
  );

  prog_seq #(.PROG_CYC(PROG_CYC), .BLKW(NBLK_W)) u_seq (
    .clk, .rst_n, .start_req(start_req), .wren(ctl_wdata[0]),
    .erase_sel(ctl_wdata[1]), .blk_in(ptr[MEM_LG-1:BLK_LG]),
    .busy(busy), .err(err), .commit(commit), .commit_erase(commit_erase),
    .commit_blk(commit_blk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tablat <= '0;
    else if (rd_acc) tablat <= rd_byte;
    else if (lat_we) tablat <= lat_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_wren  <= 1'b0;
      ctl_erase <= 1'b0;
    end else if (ctl_we) begin
      ctl_wren  <= ctl_wdata[0];
      ctl_erase <= ctl_wdata[1];
    end
  end
endmodule

// File: rtl/tblflash_chk.sv
module tblflash_chk #(
  parameter int PTR_W    = 22,
  parameter int PROG_CYC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             ptr_we,
  input logic [PTR_W-1:0] ptr,
  input logic             lat_we,
  input logic [7:0]       tablat,
  input logic             ctl_we,
  input logic [2:0]       ctl_wdata,
  input logic             busy,
  input logic             err
);
  localparam int CW = $clog2(PROG_CYC + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + CW'(1);
    else           run_q <= '0;
  end

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[2] && ctl_wdata[0] && !busy) |=> busy); // R7
  AST_NOWREN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[2] && !ctl_wdata[0] && !busy) |=> (err && !busy)); // R9
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < CW'(PROG_CYC))); // R8
  AST_STALL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lat_we) |=> $stable(tablat)); // R7
  AST_STALL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ptr_we) |=> $stable(ptr)); // R7
  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && !(cmd_valid && cmd_ready)) |=> $stable(ptr)); // R3
endmodule

bind tblflash_ctrl tblflash_chk #(.PTR_W(PTR_W), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .ptr_we(ptr_we), .ptr(ptr), .lat_we(lat_we), .tablat(tablat),
  .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .busy(busy), .err(err)
);

// File: tb/tb_tblflash_ctrl.sv
`timescale 1ns/1ps
module tb_tblflash_ctrl;
  localparam int PTR_W = 22, MEM_LG = 9, BLK_LG = 6, PROG_CYC = 16;
  localparam int NBYTES = 2 ** MEM_LG, BLK = 2 ** BLK_LG;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready, cmd_op = 0;
  logic [1:0] cmd_mode = 0;
  logic ptr_we = 0, lat_we = 0, ctl_we = 0;
  logic [PTR_W-1:0] ptr_wdata = '0, ptr;
  logic [7:0] lat_wdata = '0, tablat;
  logic [2:0] ctl_wdata = '0;
  logic ctl_wren, ctl_erase, busy, err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tblflash_ctrl #(.PTR_W(PTR_W), .MEM_LG(MEM_LG), .BLK_LG(BLK_LG), .PROG_CYC(PROG_CYC)) dut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_mode, .ptr_we, .ptr_wdata,
    .ptr, .lat_we, .lat_wdata, .tablat, .ctl_we, .ctl_wdata, .ctl_wren, .ctl_erase,
    .busy, .err);

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tbl(logic op, logic [1:0] m);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_mode = m;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic set_ptr(logic [PTR_W-1:0] v);
    @(negedge clk); ptr_we = 1; ptr_wdata = v;
    @(negedge clk); ptr_we = 0;
  endtask

  task automatic set_lat(logic [7:0] v);
    @(negedge clk); lat_we = 1; lat_wdata = v;
    @(negedge clk); lat_we = 0;
  endtask

  task automatic ctl_wr(logic [2:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd_at(int a, logic [7:0] exp, string req);
    set_ptr(PTR_W'(a));
    tbl(1'b0, 2'd0);
    chk(tablat == exp, req, tablat, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ptr == 0 && tablat == 0, "R1", {ptr, tablat}, 0);
    chk(!ctl_wren && !ctl_erase && !busy && !err && cmd_ready, "R1",
        {ctl_wren, ctl_erase, busy, err, cmd_ready}, 1);
    tbl(1'b0, 2'd1);
    chk(tablat == 8'hFF, "R1", tablat, 8'hFF);

    // R11 control register
    ctl_wr(3'b011);
    chk(ctl_wren && ctl_erase && !busy, "R11", {ctl_wren, ctl_erase, busy}, 3'b110);
    ctl_wr(3'b001);
    chk(ctl_wren && !ctl_erase, "R11", {ctl_wren, ctl_erase}, 2'b10);

    // fill every block through the staging buffer
    for (int b = 0; b < NBYTES / BLK; b++) begin
      set_ptr(PTR_W'(b * BLK));
      for (int i = 0; i < BLK; i++) begin
        set_lat(pat(b * BLK + i));
        tbl(1'b1, 2'd1);
      end
      if (b == 0) begin
        rd_at(5, 8'hFF, "R4");           // store untouched before commit
      end
      set_ptr(PTR_W'(b * BLK + 37));     // R5 low bits ignored
      ctl_wr(3'b101);
      if (b == 0) begin
        chk(busy && !cmd_ready, "R7", {busy, cmd_ready}, 2'b10);
        n = 0;
        while (busy) begin
          n++;
          if (n == 3) begin ctl_we = 1; ctl_wdata = 3'b111; end // R8 start while busy
          else ctl_we = 0;
          if (n == 5) begin
            cmd_valid = 1; cmd_op = 0; cmd_mode = 2'd1;
          end
          @(negedge clk);
          if (n == 5) begin
            chk(ptr == PTR_W'(37), "R7", ptr, 37);
            cmd_valid = 0;
          end
        end
        ctl_we = 0;
        chk(n == PROG_CYC, "R7", n, PROG_CYC);   // R8 not extended
      end
      wait_idle();
    end

    // R2/R3 sweep all bytes with post-increment
    set_ptr('0);
    bad = 0;
    for (int a = 0; a < NBYTES; a++) begin
      tbl(1'b0, 2'd1);
      if (tablat != pat(a)) begin
        bad++;
        chk(0, "R2", tablat, pat(a));
      end
    end
    chk(bad == 0, "R5", bad, 0);
    chk(ptr == PTR_W'(NBYTES), "R3", ptr, NBYTES);

    // R2 aliasing of upper pointer bits
    set_ptr(22'h3FFE00 | 22'd5);
    tbl(1'b0, 2'd0);
    chk(tablat == pat(5), "R2", tablat, pat(5));
    chk(ptr == (22'h3FFE00 | 22'd5), "R3", ptr, 22'h3FFE05);

    // R3 other modes
    set_ptr(22'd100);
    tbl(1'b0, 2'd2);
    chk(tablat == pat(100) && ptr == 22'd99, "R3", {ptr, tablat}, {22'd99, pat(100)});
    tbl(1'b0, 2'd3);
    chk(tablat == pat(100) && ptr == 22'd100, "R3", {ptr, tablat}, {22'd100, pat(100)});
    set_ptr('0);
    tbl(1'b0, 2'd2);
    chk(ptr == 22'h3FFFFF && tablat == pat(0), "R3", ptr, 22'h3FFFFF);
    tbl(1'b0, 2'd1);
    chk(ptr == 22'd0 && tablat == pat(511), "R3", {ptr, tablat}, pat(511));

    // R6 erase block 2 with junk staged
    set_ptr(22'd130);
    set_lat(8'h12);
    tbl(1'b1, 2'd1);
    set_ptr(PTR_W'(2 * BLK + 5));
    ctl_wr(3'b111);
    wait_idle();
    set_ptr(PTR_W'(2 * BLK));
    bad = 0;
    for (int i = 0; i < BLK; i++) begin
      tbl(1'b0, 2'd1);
      if (tablat != 8'hFF) bad++;
    end
    chk(bad == 0, "R6", bad, 0);
    rd_at(BLK + 63, pat(BLK + 63), "R6");
    rd_at(3 * BLK, pat(3 * BLK), "R6");

    // R10 staging reset after the erase commit
    set_ptr(PTR_W'(5 * BLK + 3));
    set_lat(8'h5A);
    tbl(1'b1, 2'd0);
    ctl_wr(3'b101);
    wait_idle();
    rd_at(5 * BLK + 3, 8'h5A, "R10");
    rd_at(5 * BLK + 2, 8'hFF, "R10");
    rd_at(5 * BLK + 2, 8'hFF, "R10");   // staged junk byte from erase gone
    rd_at(2 * BLK + 2, 8'hFF, "R10");

    // R9 start without enable
    set_ptr(PTR_W'(5 * BLK));
    ctl_wr(3'b100);
    chk(err && !busy, "R9", {err, busy}, 2'b10);
    rd_at(5 * BLK + 3, 8'h5A, "R9");
    set_ptr(PTR_W'(7 * BLK));
    ctl_wr(3'b101);
    chk(!err && busy, "R9", {err, busy}, 2'b01);
    wait_idle();
    rd_at(7 * BLK, 8'hFF, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule